// File: doc/BRIEF.md
# IPC-Driven Frequency Level Stepper

This block decides the clock level of a core from how its throughput moves. Every cycle it receives the number of instructions the core retired. It groups cycles into windows of fixed length. At the end of each window it compares the window's instructions-per-cycle with that of the window before. A rise of five percent or more moves the clock up by one 125 MHz notch. A fall of the same size moves it down by one notch, since falling throughput points to stall-bound execution. Smaller moves leave the clock where it is.

The comparison needs no divider. The two windows' instruction counts are cross-multiplied with their cycle counts, and the five percent test becomes a multiply by twenty and a compare. The level index counts notches above 500 MHz, so level i means 500 + 125·i MHz. A quasi-static select input chooses the top level: level 7 (1375 MHz) or level 6 (1250 MHz). A one-cycle strobe marks every change of level.

Top module: `ipc_dvfs_stepper`

## Requirements
- R1: While rst_n is low at a clock edge, the level becomes 0 (500 MHz), the strobe is 0, and any stored reference window is discarded.
- R2: A window is exactly WIN_LEN cycles long, and its instruction total is the sum of retire_cnt_i over those cycles, however unevenly the count is spread.
- R3: The first window that completes after reset only becomes the reference. It never changes the level or raises the strobe.
- R4: Let a = current instructions × reference cycles and b = reference instructions × current cycles. When a > b and 20·(a−b) ≥ b, the level goes up by one.
- R5: When b > a and 20·(b−a) ≥ b, the level goes down by one.
- R6: When a = b, or when 20·|a−b| < b, the level holds and no strobe is raised. This includes two windows in a row that both retire nothing.
- R7: At the end of every window the reference is replaced by that window's counts, whether or not a step was taken.
- R8: Each window causes at most one step, of exactly one level. upd_o is a one-cycle pulse, high in the cycle that starts with the second clock edge after the edge that samples the window's last retire_cnt_i. lvl_o changes only together with upd_o.
- R9: The top level is 7 when cap_hi_i is 1 and 6 when it is 0, with cap_hi_i sampled at the edge where the step is applied. An upward step at or above the top level is dropped, and no strobe is raised.
- R10: A downward step at level 0 is dropped, and no strobe is raised.
- R11: A window in which every cycle carries the largest retire_cnt_i value is totalled without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| retire_cnt_i | input | INC_W | Instructions retired in this cycle |
| cap_hi_i | input | 1 | 1: top level 7 (1375 MHz); 0: top level 6 (1250 MHz) |
| lvl_o | output | LVL_W | Frequency level, 500 + 125·lvl_o MHz |
| upd_o | output | 1 | One-cycle strobe when lvl_o changes |

## Verification
The hardest case to reach is the exact edge of the five percent band. There the outcome depends on whole instruction counts, on which window serves as the reference, and on the fact that the reference moves even in windows that do not step. The stimulus uses a short window and spreads each chosen total unevenly across its cycles. It then walks a chain of totals: one sits exactly on the threshold, and others sit one count inside it. Two of them are set so that a reference held only on steps would give the opposite decision. Level limits are reached by a run of rising totals with the top-level select switched between windows.

// File: rtl/ipc_dvfs_pkg.sv
// Package: shared types for the IPC-driven frequency stepper.
// Assumes: one step decision per window, carried as a small enum.
package ipc_dvfs_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/ipc_win_counter.sv
// Module: ipc_win_counter
// Splits time into windows of WIN_LEN cycles and sums the retired-instruction
// count over each one. For one cycle after a window's last cycle it presents
// the window's instruction and cycle totals with win_valid_o high.
// Assumes: WIN_LEN >= 2, and SUM_W is wide enough for WIN_LEN * max increment.
module ipc_win_counter #(
    parameter int WIN_LEN = 65536,
    parameter int INC_W   = 3,
    parameter int CYC_W   = 17,
    parameter int SUM_W   = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc_i,
    output logic             win_valid_o,
    output logic [SUM_W-1:0] win_instr_o,
    output logic [CYC_W-1:0] win_cyc_o
);

    localparam int MAX_INC = (1 << INC_W) - 1;

    logic [CYC_W-1:0] cyc_q;
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] sum_next;
    logic             last_cyc;
    logic             win_valid_q;
    logic [SUM_W-1:0] win_instr_q;
    logic [CYC_W-1:0] win_cyc_q;

    // Running total including this cycle's increment, and the end-of-window flag.
    always_comb begin
        sum_next = acc_q + SUM_W'(inc_i);
        last_cyc = (cyc_q == CYC_W'(WIN_LEN - 1));
    end

    // Advance the cycle position, accumulate, and latch the totals at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q       <= '0;
            acc_q       <= '0;
            win_valid_q <= 1'b0;
            win_instr_q <= '0;
            win_cyc_q   <= '0;
        end else begin
            win_valid_q <= last_cyc;
            if (last_cyc) begin
                cyc_q       <= '0;
                acc_q       <= '0;
                win_instr_q <= sum_next;
                win_cyc_q   <= cyc_q + CYC_W'(1);
            end else begin
                cyc_q <= cyc_q + CYC_W'(1);
                acc_q <= sum_next;
            end
        end
    end

    assign win_valid_o = win_valid_q;
    assign win_instr_o = win_instr_q;
    assign win_cyc_o   = win_cyc_q;

    // R2: the cycle position never leaves the window.
    p_cyc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q < CYC_W'(WIN_LEN));

    // R2: the window-end pulse lasts one cycle.
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_q |=> !win_valid_q);

    // R11: a presented total never exceeds a full window of largest increments.
    p_sum_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_q |-> (win_instr_q <= SUM_W'(WIN_LEN * MAX_INC)));

endmodule

// File: rtl/ipc_change_judge.sv
// Module: ipc_change_judge
// Keeps the previous window's counts as the reference. At each window end it
// decides whether the IPC moved by at least 1/THR in relative terms. It uses
// cross-multiplication (a = cur_instr*ref_cyc, b = ref_instr*cur_cyc) and the
// test THR*|a-b| >= b, with a != b. The decision is registered as a one-cycle step.
// Assumes: win_valid_i is a single-cycle pulse, and the first window is stored only.
module ipc_change_judge
    import ipc_dvfs_pkg::*;
#(
    parameter int SUM_W = 19,
    parameter int CYC_W = 17,
    parameter int THR   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid_i,
    input  logic [SUM_W-1:0] win_instr_i,
    input  logic [CYC_W-1:0] win_cyc_i,
    output step_e            step_o
);

    localparam int PROD_W = SUM_W + CYC_W;
    localparam int SCL_W  = PROD_W + $clog2(THR + 1);

    logic [SUM_W-1:0]  ref_instr_q;
    logic [CYC_W-1:0]  ref_cyc_q;
    logic              have_ref_q;
    step_e             step_q;

    logic [PROD_W-1:0] prod_cur;
    logic [PROD_W-1:0] prod_ref;
    logic [PROD_W-1:0] gap;
    logic [SCL_W-1:0]  gap_scaled;
    logic              moved;

    // Cross-multiply the two windows and scale their gap by the threshold.
    always_comb begin
        prod_cur   = PROD_W'(win_instr_i) * PROD_W'(ref_cyc_q);
        prod_ref   = PROD_W'(ref_instr_q) * PROD_W'(win_cyc_i);
        gap        = (prod_cur > prod_ref) ? (prod_cur - prod_ref) : (prod_ref - prod_cur);
        gap_scaled = SCL_W'(gap) * SCL_W'(THR);
        moved      = (gap != '0) && (gap_scaled >= SCL_W'(prod_ref));
    end

    // Refresh the reference at every window end and register the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_instr_q <= '0;
            ref_cyc_q   <= '0;
            have_ref_q  <= 1'b0;
            step_q      <= STEP_NONE;
        end else begin
            step_q <= STEP_NONE;
            if (win_valid_i) begin
                ref_instr_q <= win_instr_i;
                ref_cyc_q   <= win_cyc_i;
                have_ref_q  <= 1'b1;
                if (have_ref_q && moved) begin
                    step_q <= (prod_cur > prod_ref) ? STEP_UP : STEP_DOWN;
                end
            end
        end
    end

    assign step_o = step_q;

    // R3: the window that first fills the reference never yields a step.
    p_first_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_i && !have_ref_q) |=> (step_q == STEP_NONE));

    // R4: a step appears only in the cycle after a window-end pulse.
    p_step_after_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != STEP_NONE) |-> $past(win_valid_i));

    // R8: a step request lasts one cycle.
    p_step_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != STEP_NONE) |=> (step_q == STEP_NONE));

endmodule

// File: rtl/freq_level_stepper.sv
// Module: freq_level_stepper
// Holds the frequency level and applies one-notch step requests within the
// floor (level 0) and the selected ceiling. A strobe marks each applied step.
// Assumes: step_i is a one-cycle request, and cap_hi_i is quasi-static.
module freq_level_stepper
    import ipc_dvfs_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int TOP_HI = 7,
    parameter int TOP_LO = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step_i,
    input  logic             cap_hi_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic             upd_o
);

    localparam logic [LVL_W-1:0] TOP_HI_L = LVL_W'(TOP_HI);
    localparam logic [LVL_W-1:0] TOP_LO_L = LVL_W'(TOP_LO);

    logic [LVL_W-1:0] lvl_q;
    logic             upd_q;
    logic [LVL_W-1:0] top_lvl;
    logic             may_rise;
    logic             may_fall;

    // Select the ceiling and find which directions are open.
    always_comb begin
        top_lvl  = cap_hi_i ? TOP_HI_L : TOP_LO_L;
        may_rise = (lvl_q < top_lvl);
        may_fall = (lvl_q != '0);
    end

    // Apply an allowed step and raise the strobe for exactly that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (step_i == STEP_UP && may_rise) begin
                lvl_q <= lvl_q + LVL_W'(1);
                upd_q <= 1'b1;
            end else if (step_i == STEP_DOWN && may_fall) begin
                lvl_q <= lvl_q - LVL_W'(1);
                upd_q <= 1'b1;
            end
        end
    end

    assign lvl_o = lvl_q;
    assign upd_o = upd_q;

    // R8: every strobed change is exactly one notch.
    p_one_notch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> ((lvl_q == $past(lvl_q) + LVL_W'(1)) || (lvl_q == $past(lvl_q) - LVL_W'(1))));

    // R8: the level never moves without the strobe.
    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_q |-> (lvl_q == $past(lvl_q)));

    // R9: an upward request at the ceiling is dropped.
    p_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_UP && lvl_q >= top_lvl) |=> !upd_q);

    // R10: a downward request at the floor is dropped and the level stays at zero.
    p_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_DOWN && lvl_q == '0) |=> (!upd_q && lvl_q == '0));

endmodule

// File: rtl/ipc_dvfs_stepper.sv
// Module: ipc_dvfs_stepper (top)
// Moves a core's frequency level up or down by one notch when the IPC of
// a fixed-length window differs from the previous window's IPC by at least 1/THR.
// Level i means 500 + 125*i MHz. The ceiling is chosen by cap_hi_i.
// Assumes: retire_cnt_i is valid every cycle, and cap_hi_i changes rarely.
module ipc_dvfs_stepper
    import ipc_dvfs_pkg::*;
#(
    parameter int WIN_LEN = 65536,
    parameter int INC_W   = 3,
    parameter int LVL_W   = 3,
    parameter int TOP_HI  = 7,
    parameter int TOP_LO  = 6,
    parameter int THR     = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] retire_cnt_i,
    input  logic             cap_hi_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic             upd_o
);

    localparam int MAX_INC = (1 << INC_W) - 1;
    localparam int CYC_W   = $clog2(WIN_LEN + 1);
    localparam int SUM_W   = $clog2(WIN_LEN * MAX_INC + 1);

    logic             win_valid;
    logic [SUM_W-1:0] win_instr;
    logic [CYC_W-1:0] win_cyc;
    step_e            step_req;

    ipc_win_counter #(
        .WIN_LEN (WIN_LEN),
        .INC_W   (INC_W),
        .CYC_W   (CYC_W),
        .SUM_W   (SUM_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (retire_cnt_i),
        .win_valid_o (win_valid),
        .win_instr_o (win_instr),
        .win_cyc_o   (win_cyc)
    );

    ipc_change_judge #(
        .SUM_W (SUM_W),
        .CYC_W (CYC_W),
        .THR   (THR)
    ) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_valid_i (win_valid),
        .win_instr_i (win_instr),
        .win_cyc_i   (win_cyc),
        .step_o      (step_req)
    );

    freq_level_stepper #(
        .LVL_W  (LVL_W),
        .TOP_HI (TOP_HI),
        .TOP_LO (TOP_LO)
    ) u_stepper (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step_req),
        .cap_hi_i (cap_hi_i),
        .lvl_o    (lvl_o),
        .upd_o    (upd_o)
    );

    // R1: the strobe stays low in the first cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!upd_o && lvl_o == '0));

endmodule

// File: tb/ipc_dvfs_stepper_test.sv
module ipc_dvfs_stepper_test;

    localparam int WL   = 16;
    localparam int NVEC = 26;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] retire_cnt = '0;
    logic       cap_hi = 1'b1;
    logic [2:0] lvl;
    logic       upd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit    pend_valid = 1'b0;
    int    pend_lvl = 0;
    int    pend_upd = 0;
    string pend_tag = "";

    // Window totals, cap select, expected level, expected strobe, requirement.
    localparam int VN   [NVEC] = '{50, 100, 105, 109, 104, 99, 94, 0, 0, 50, 20, 10,
                                   20, 30, 40, 50, 60, 70, 80, 100,
                                   50, 90, 40, 60, 80, 112};
    localparam int VCAP [NVEC] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1,
                                   1, 1, 1, 1, 1, 1, 1, 1,
                                   1, 0, 0, 0, 0, 1};
    localparam int VLVL [NVEC] = '{0, 1, 2, 2, 2, 2, 1, 0, 0, 1, 0, 0,
                                   1, 2, 3, 4, 5, 6, 7, 7,
                                   6, 6, 5, 6, 6, 7};
    localparam int VUPD [NVEC] = '{0, 1, 1, 0, 0, 0, 1, 1, 0, 1, 1, 0,
                                   1, 1, 1, 1, 1, 1, 1, 0,
                                   1, 0, 1, 1, 0, 1};
    string VTAG [NVEC] = '{"R3", "R4", "R4", "R6", "R6", "R7", "R5", "R5", "R6", "R4", "R5", "R10",
                           "R2", "R4", "R4", "R4", "R4", "R4", "R9", "R9",
                           "R5", "R9", "R5", "R4", "R9", "R11"};

    ipc_dvfs_stepper #(.WIN_LEN(WL)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .retire_cnt_i (retire_cnt),
        .cap_hi_i     (cap_hi),
        .lvl_o        (lvl),
        .upd_o        (upd)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one window (called at a negedge); checks the previous window's result.
    task automatic run_window(input int n, input int cap, input int exp_lvl,
                              input int exp_upd, input string tag);
        for (int j = 0; j < WL; j++) begin
            retire_cnt = 3'((j < (n % WL)) ? (n / WL + 1) : (n / WL));
            if (j == 2 && pend_valid) begin
                chk({pend_tag, " level"}, int'(lvl), pend_lvl);
                chk({pend_tag, " strobe"}, int'(upd), pend_upd);
            end
            if (j == 3) begin
                cap_hi = cap[0];
                if (pend_valid) chk("R8 strobe single cycle", int'(upd), 0);
            end
            @(negedge clk);
        end
        pend_valid = 1'b1;
        pend_lvl   = exp_lvl;
        pend_upd   = exp_upd;
        pend_tag   = tag;
    endtask

    task automatic finish_pending();
        retire_cnt = '0;
        @(negedge clk);
        @(negedge clk);
        chk({pend_tag, " level"}, int'(lvl), pend_lvl);
        chk({pend_tag, " strobe"}, int'(upd), pend_upd);
        @(negedge clk);
        chk("R8 strobe single cycle", int'(upd), 0);
        pend_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset level", int'(lvl), 0);
        chk("R1 reset strobe", int'(upd), 0);
        rst_n = 1'b1;
        for (int k = 0; k < NVEC; k++) begin
            run_window(VN[k], VCAP[k], VLVL[k], VUPD[k], VTAG[k]);
        end
        finish_pending();

        // Reset in the middle of a window, from a raised level.
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 mid-run reset level", int'(lvl), 0);
        chk("R1 mid-run reset strobe", int'(upd), 0);
        rst_n = 1'b1;
        cap_hi = 1'b1;
        run_window(30, 1, 0, 0, "R3 first window after reset");
        run_window(60, 1, 1, 1, "R4 step after new reference");
        finish_pending();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule